// File: doc/BRIEF.md
# Operand Barrel Shifter with Rotated Immediate

This block forms the second ALU operand of a data-processing datapath in a single combinational pass. It draws on one of two sources. The first is a 12-bit constant field: an 8-bit base is widened to 32 bits and rotated right by an even number of places, which lets a small field express many useful constants. The second is a 32-bit register value that passes through a shifter. The shifter offers logical left, logical right, arithmetic right and rotate right, plus a one-place rotate that runs through the carry flag.

The shift amount has two possible sources. It can come from a 5-bit field of the instruction, or from the low byte of a second register. The two sources treat a zero amount, and amounts of 32 or more, differently. Next to the 32-bit operand the block also returns a shifter carry. The flag logic uses that carry as the C flag of logical operations, and the incoming carry flag is passed through whenever no bit is shifted out.

Upstream logic supplies the register values and decoded fields. The outputs go straight to the ALU input and to the flag-update path.

Top module: `opnd_shifter`

## Requirements
- R1: With `use_imm`=1, `operand_out` equals `imm_field[7:0]` zero-extended to 32 bits and rotated right by 2×`imm_field[11:8]` places. For example, base 0x40 with rotate field 13 gives 0x0000_1000.
- R2: With `use_imm`=1, `carry_out` equals `carry_in` when `imm_field[11:8]`=0, and equals `operand_out[31]` otherwise.
- R3: With `use_imm`=0, `amt_from_reg`=0 and `shift_kind`=00 (logical left), an amount n of 0 passes `rm_value` and `carry_in` through unchanged. For n of 1 to 31 the result is `rm_value` shifted left with zeros filled in, and the carry is `rm_value[32-n]`.
- R4: With an instruction-field amount and `shift_kind`=01 (logical right) or 10 (arithmetic right), an amount n of 1 to 31 shifts right with zero or sign fill and gives carry `rm_value[n-1]`. An amount of 0 means a 32-place shift: the result is 0 for 01 and all copies of bit 31 for 10, and the carry is `rm_value[31]`.
- R5: With an instruction-field amount and `shift_kind`=11 (rotate right), an amount n of 1 to 31 rotates right and gives carry `rm_value[n-1]`. An amount of 0 selects the extended rotate instead: the result is {`carry_in`, `rm_value[31:1]`} and the carry is `rm_value[0]`.
- R6: With `amt_from_reg`=1, the amount is `rs_low_byte`. An amount of 0 leaves `rm_value` and `carry_in` unchanged for every shift kind. For logical left or right, an amount of 1 to 31 behaves as in R3 and R4.
- R7: With a register amount, a logical left or right shift by exactly 32 gives 0, with carry `rm_value[0]` for left and `rm_value[31]` for right. Any amount above 32 gives 0 with carry 0.
- R8: With a register amount, an arithmetic right shift of 1 to 31 behaves as in R4. An amount of 32 or more fills every bit with `rm_value[31]` and gives carry `rm_value[31]`.
- R9: With a register amount, a rotate right uses the amount modulo 32. A nonzero amount that is a multiple of 32 leaves the value unchanged with carry `rm_value[31]`. Any other nonzero amount r (mod 32) rotates and gives carry `rm_value[r-1]`.
- R10: With `use_imm`=1 the register, shift and amount inputs have no effect on either output. With `use_imm`=0, `imm_field` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| use_imm | input | 1 | 1 selects the rotated constant, 0 selects the shifted register |
| imm_field | input | 12 | Bits 11:8 are the rotate count, bits 7:0 are the base value |
| rm_value | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_from_reg | input | 1 | 1 takes the amount from `rs_low_byte`, 0 from `shamt_imm` |
| shamt_imm | input | 5 | Shift amount from the instruction field |
| rs_low_byte | input | 8 | Low byte of the register that supplies the amount |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Operand delivered to the ALU |
| carry_out | output | 1 | Shifter carry for flag update |

## Verification
The value path and the carry path act on the same vector in the same evaluation, and in the extended rotate they cross: the incoming carry enters the result's top bit while the value's bottom bit becomes the outgoing carry. The sweeps provoke this by driving `carry_in` both ways against register values whose bit 0 and bit 31 differ. A single 33-bit comparison of {carry, operand} then judges both results together, so a design that mixes up the two paths fails on the same vector. The same joint comparison covers the register-amount boundaries at 0, 32, 33 and 255, where the value becomes 0 or saturates while the carry comes from an edge bit or is forced low.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    // Shift selector as seen on the top-level port
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    // Normalised operation handed from the amount decoder to the shift core
    typedef enum logic [2:0] {
        CORE_PASS = 3'd0,
        CORE_LSL  = 3'd1,
        CORE_LSR  = 3'd2,
        CORE_ASR  = 3'd3,
        CORE_ROR  = 3'd4,
        CORE_RRX  = 3'd5,
        CORE_ZERO = 3'd6
    } core_op_e;

endpackage

// File: rtl/opnd_imm_rotator.sv
module opnd_imm_rotator
    import opnd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BASE_W = 8,
    parameter int ROT_W  = 4
) (
    input  logic [BASE_W+ROT_W-1:0] imm_field,
    input  logic                    carry_in,
    output logic [DATA_W-1:0]       imm_value,
    output logic                    imm_carry
);

    localparam int IMM_W = BASE_W + ROT_W;

    logic [ROT_W-1:0]  rot_cnt;
    logic [DATA_W-1:0] stage [ROT_W+1];

    assign rot_cnt  = imm_field[IMM_W-1:BASE_W];
    assign stage[0] = DATA_W'(imm_field[BASE_W-1:0]);

    // Logarithmic rotator: rotate-count bit k rotates by 2^(k+1) places
    for (genvar k = 0; k < ROT_W; k++) begin : g_rot_stage
        localparam int STEP = 2 << k;
        assign stage[k+1] = rot_cnt[k]
                          ? {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]}
                          : stage[k];
    end

    assign imm_value = stage[ROT_W];
    assign imm_carry = (rot_cnt == '0) ? carry_in : imm_value[DATA_W-1];

endmodule

// File: rtl/opnd_amount_decode.sv
module opnd_amount_decode
    import opnd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SHAMT_W  = 5,
    parameter int REGAMT_W = 8,
    localparam int AMT_W   = $clog2(DATA_W) + 1,
    localparam int LOG_W   = $clog2(DATA_W)
) (
    input  shift_kind_e         kind,
    input  logic                amt_from_reg,
    input  logic [SHAMT_W-1:0]  shamt_imm,
    input  logic [REGAMT_W-1:0] rs_low_byte,
    output core_op_e            core_op,
    output logic [AMT_W-1:0]    core_amt
);

    localparam logic [AMT_W-1:0]    FULL_AMT = AMT_W'(DATA_W);
    localparam logic [REGAMT_W-1:0] FULL_REG = REGAMT_W'(DATA_W);

    logic [LOG_W-1:0] rot_mod;
    assign rot_mod = rs_low_byte[LOG_W-1:0];

    always_comb begin
        core_op  = CORE_PASS;
        core_amt = '0;
        if (!amt_from_reg) begin
            // Instruction-field amount: zero is a special encoding per kind
            unique case (kind)
                SK_LSL: begin
                    core_op  = (shamt_imm == '0) ? CORE_PASS : CORE_LSL;
                    core_amt = AMT_W'(shamt_imm);
                end
                SK_LSR: begin
                    core_op  = CORE_LSR;
                    core_amt = (shamt_imm == '0) ? FULL_AMT : AMT_W'(shamt_imm);
                end
                SK_ASR: begin
                    core_op  = CORE_ASR;
                    core_amt = (shamt_imm == '0) ? FULL_AMT : AMT_W'(shamt_imm);
                end
                SK_ROR: begin
                    core_op  = (shamt_imm == '0) ? CORE_RRX : CORE_ROR;
                    core_amt = AMT_W'(shamt_imm);
                end
                default: core_op = CORE_PASS;
            endcase
        end else if (rs_low_byte != '0) begin
            // Register amount: zero is a pure pass, large values saturate
            unique case (kind)
                SK_LSL: begin
                    core_op  = (rs_low_byte > FULL_REG) ? CORE_ZERO : CORE_LSL;
                    core_amt = AMT_W'(rs_low_byte);
                end
                SK_LSR: begin
                    core_op  = (rs_low_byte > FULL_REG) ? CORE_ZERO : CORE_LSR;
                    core_amt = AMT_W'(rs_low_byte);
                end
                SK_ASR: begin
                    core_op  = CORE_ASR;
                    core_amt = (rs_low_byte >= FULL_REG) ? FULL_AMT
                                                         : AMT_W'(rs_low_byte);
                end
                SK_ROR: begin
                    core_op  = CORE_ROR;
                    core_amt = (rot_mod == '0) ? FULL_AMT : AMT_W'(rot_mod);
                end
                default: core_op = CORE_PASS;
            endcase
        end
    end

endmodule

// File: rtl/opnd_barrel_core.sv
module opnd_barrel_core
    import opnd_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W) + 1
) (
    input  core_op_e          core_op,
    input  logic [AMT_W-1:0]  core_amt,
    input  logic [DATA_W-1:0] value,
    input  logic              carry_in,
    output logic [DATA_W-1:0] shifted,
    output logic              shift_carry
);

    logic [2*DATA_W-1:0] left_w;
    logic [2*DATA_W:0]   right_w;
    logic [DATA_W-1:0]   fill;

    // Right-shift fill source: zeros, sign copies, or the value for rotation
    always_comb begin
        unique case (core_op)
            CORE_ASR: fill = {DATA_W{value[DATA_W-1]}};
            CORE_ROR: fill = value;
            default:  fill = '0;
        endcase
    end

    // Guard bit below the value collects the last bit shifted out to the right
    assign left_w  = {{DATA_W{1'b0}}, value} << core_amt;
    assign right_w = {fill, value, 1'b0} >> core_amt;

    always_comb begin
        shifted     = value;
        shift_carry = carry_in;
        unique case (core_op)
            CORE_PASS: begin
                shifted     = value;
                shift_carry = carry_in;
            end
            CORE_LSL: begin
                shifted     = left_w[DATA_W-1:0];
                shift_carry = left_w[DATA_W];
            end
            CORE_LSR, CORE_ASR, CORE_ROR: begin
                shifted     = right_w[DATA_W:1];
                shift_carry = right_w[0];
            end
            CORE_RRX: begin
                shifted     = {carry_in, value[DATA_W-1:1]};
                shift_carry = value[0];
            end
            CORE_ZERO: begin
                shifted     = '0;
                shift_carry = 1'b0;
            end
            default: begin
                shifted     = value;
                shift_carry = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import opnd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BASE_W   = 8,
    parameter int ROT_W    = 4,
    parameter int SHAMT_W  = 5,
    parameter int REGAMT_W = 8
) (
    input  logic                    use_imm,
    input  logic [BASE_W+ROT_W-1:0] imm_field,
    input  logic [DATA_W-1:0]       rm_value,
    input  logic [1:0]              shift_kind,
    input  logic                    amt_from_reg,
    input  logic [SHAMT_W-1:0]      shamt_imm,
    input  logic [REGAMT_W-1:0]     rs_low_byte,
    input  logic                    carry_in,
    output logic [DATA_W-1:0]       operand_out,
    output logic                    carry_out
);

    localparam int AMT_W = $clog2(DATA_W) + 1;

    shift_kind_e       kind;
    core_op_e          core_op;
    logic [AMT_W-1:0]  core_amt;
    logic [DATA_W-1:0] imm_value;
    logic              imm_carry;
    logic [DATA_W-1:0] reg_value;
    logic              reg_carry;

    assign kind = shift_kind_e'(shift_kind);

    opnd_imm_rotator #(
        .DATA_W (DATA_W),
        .BASE_W (BASE_W),
        .ROT_W  (ROT_W)
    ) u_imm (
        .imm_field (imm_field),
        .carry_in  (carry_in),
        .imm_value (imm_value),
        .imm_carry (imm_carry)
    );

    opnd_amount_decode #(
        .DATA_W   (DATA_W),
        .SHAMT_W  (SHAMT_W),
        .REGAMT_W (REGAMT_W)
    ) u_dec (
        .kind         (kind),
        .amt_from_reg (amt_from_reg),
        .shamt_imm    (shamt_imm),
        .rs_low_byte  (rs_low_byte),
        .core_op      (core_op),
        .core_amt     (core_amt)
    );

    opnd_barrel_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .core_op     (core_op),
        .core_amt    (core_amt),
        .value       (rm_value),
        .carry_in    (carry_in),
        .shifted     (reg_value),
        .shift_carry (reg_carry)
    );

    // Source select: constant path or shifted register path
    always_comb begin
        if (use_imm) begin
            operand_out = imm_value;
            carry_out   = imm_carry;
        end else begin
            operand_out = reg_value;
            carry_out   = reg_carry;
        end
    end

endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
    parameter int DATA_W   = 32,
    parameter int BASE_W   = 8,
    parameter int ROT_W    = 4,
    parameter int SHAMT_W  = 5,
    parameter int REGAMT_W = 8
) (
    input logic                    use_imm,
    input logic [BASE_W+ROT_W-1:0] imm_field,
    input logic [DATA_W-1:0]       rm_value,
    input logic [1:0]              shift_kind,
    input logic                    amt_from_reg,
    input logic [SHAMT_W-1:0]      shamt_imm,
    input logic [REGAMT_W-1:0]     rs_low_byte,
    input logic                    carry_in,
    input logic [DATA_W-1:0]       operand_out,
    input logic                    carry_out
);

    localparam int IMM_W = BASE_W + ROT_W;

    logic known;
    assign known = !$isunknown({use_imm, imm_field, rm_value, shift_kind,
                                amt_from_reg, shamt_imm, rs_low_byte, carry_in});

    always_comb begin
        if (known) begin
            if (use_imm && imm_field[IMM_W-1:BASE_W] == '0) begin
                p_imm_norot_r1: assert (operand_out == DATA_W'(imm_field[BASE_W-1:0])
                                        && carry_out == carry_in)
                    else $error("unrotated constant or its carry altered");
            end
            if (use_imm && imm_field[IMM_W-1:BASE_W] != '0) begin
                p_imm_carry_r2: assert (carry_out == operand_out[DATA_W-1])
                    else $error("rotated constant carry is not its top bit");
            end
            if (use_imm) begin
                p_imm_popcount_r1: assert ($countones(operand_out)
                                           == $countones(imm_field[BASE_W-1:0]))
                    else $error("constant rotation changed the number of ones");
            end
            if (!use_imm && !amt_from_reg && shift_kind == 2'b11 && shamt_imm == '0) begin
                p_rrx_r5: assert (operand_out == {carry_in, rm_value[DATA_W-1:1]}
                                  && carry_out == rm_value[0])
                    else $error("extended rotate result or carry wrong");
            end
            if (!use_imm && amt_from_reg && rs_low_byte == '0) begin
                p_regamt_zero_r6: assert (operand_out == rm_value && carry_out == carry_in)
                    else $error("zero register amount altered value or carry");
            end
            if (!use_imm && amt_from_reg && !shift_kind[1]
                && rs_low_byte > REGAMT_W'(DATA_W)) begin
                p_over_r7: assert (operand_out == '0 && carry_out == 1'b0)
                    else $error("oversized logical shift did not clear");
            end
            if (!use_imm && amt_from_reg && shift_kind == 2'b10
                && rs_low_byte >= REGAMT_W'(DATA_W)) begin
                p_asr_sat_r8: assert (operand_out == {DATA_W{rm_value[DATA_W-1]}}
                                      && carry_out == rm_value[DATA_W-1])
                    else $error("saturated arithmetic shift wrong");
            end
            if (!use_imm && shift_kind == 2'b11 && (amt_from_reg || shamt_imm != '0)) begin
                p_ror_pop_r9: assert ($countones(operand_out) == $countones(rm_value))
                    else $error("rotate changed the number of ones");
            end
        end
    end

endmodule

bind opnd_shifter opnd_shifter_chk #(
    .DATA_W   (DATA_W),
    .BASE_W   (BASE_W),
    .ROT_W    (ROT_W),
    .SHAMT_W  (SHAMT_W),
    .REGAMT_W (REGAMT_W)
) u_chk (
    .use_imm      (use_imm),
    .imm_field    (imm_field),
    .rm_value     (rm_value),
    .shift_kind   (shift_kind),
    .amt_from_reg (amt_from_reg),
    .shamt_imm    (shamt_imm),
    .rs_low_byte  (rs_low_byte),
    .carry_in     (carry_in),
    .operand_out  (operand_out),
    .carry_out    (carry_out)
);

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        use_imm;
    logic [11:0] imm_field;
    logic [31:0] rm_value;
    logic [1:0]  shift_kind;
    logic        amt_from_reg;
    logic [4:0]  shamt_imm;
    logic [7:0]  rs_low_byte;
    logic        carry_in;
    logic [31:0] operand_out;
    logic        carry_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    opnd_shifter u_dut (
        .use_imm      (use_imm),
        .imm_field    (imm_field),
        .rm_value     (rm_value),
        .shift_kind   (shift_kind),
        .amt_from_reg (amt_from_reg),
        .shamt_imm    (shamt_imm),
        .rs_low_byte  (rs_low_byte),
        .carry_in     (carry_in),
        .operand_out  (operand_out),
        .carry_out    (carry_out)
    );

    // ---------------- reference model ----------------
    function automatic logic [32:0] ref_imm(input logic [11:0] f, input logic cin);
        logic [31:0] b;
        logic [31:0] v;
        int r;
        b = {24'd0, f[7:0]};
        r = 2 * int'(f[11:8]);
        v = (r == 0) ? b : ((b >> r) | (b << (32 - r)));
        return {(r == 0) ? cin : v[31], v};
    endfunction

    function automatic logic [32:0] ref_lsl(input logic [31:0] v, input int k);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) o[i] = (i >= k) ? v[i-k] : 1'b0;
        return {v[32-k], o};
    endfunction

    // mode 0: zero fill, 1: sign fill, 2: rotate
    function automatic logic [32:0] ref_rsh(input logic [31:0] v, input int k, input int mode);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) begin
            int s = i + k;
            if (s < 32)         o[i] = v[s];
            else if (mode == 2) o[i] = v[s-32];
            else if (mode == 1) o[i] = v[31];
            else                o[i] = 1'b0;
        end
        return {v[k-1], o};
    endfunction

    function automatic logic [32:0] ref_reg(input logic [31:0] v, input logic [1:0] kind,
                                            input logic from_reg, input logic [4:0] sh,
                                            input logic [7:0] byt, input logic cin);
        int n;
        if (!from_reg) begin
            n = int'(sh);
            case (kind)
                2'b00:   return (n == 0) ? {cin, v} : ref_lsl(v, n);
                2'b01:   return ref_rsh(v, (n == 0) ? 32 : n, 0);
                2'b10:   return ref_rsh(v, (n == 0) ? 32 : n, 1);
                default: return (n == 0) ? {v[0], cin, v[31:1]} : ref_rsh(v, n, 2);
            endcase
        end
        n = int'(byt);
        if (n == 0) return {cin, v};
        case (kind)
            2'b00:   return (n <= 32) ? ref_lsl(v, n) : 33'd0;
            2'b01:   return (n <= 32) ? ref_rsh(v, n, 0) : 33'd0;
            2'b10:   return ref_rsh(v, (n > 32) ? 32 : n, 1);
            default: return ref_rsh(v, ((n % 32) == 0) ? 32 : (n % 32), 2);
        endcase
    endfunction

    // ---------------- check helpers ----------------
    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got carry=%0b value=%08h expected carry=%0b value=%08h",
                     tag, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic drive(input logic ui, input logic [11:0] f, input logic [31:0] v,
                         input logic [1:0] k, input logic fr, input logic [4:0] sh,
                         input logic [7:0] byt, input logic cin);
        @(negedge clk);
        use_imm = ui; imm_field = f; rm_value = v; shift_kind = k;
        amt_from_reg = fr; shamt_imm = sh; rs_low_byte = byt; carry_in = cin;
        #2;
    endtask

    function automatic string reg_tag(input logic [1:0] k, input logic fr,
                                      input logic [4:0] sh, input logic [7:0] byt);
        if (!fr) begin
            if (k == 2'b00) return "R3";
            if (k == 2'b11) return "R5";
            return "R4";
        end
        if (byt == 8'd0) return "R6";
        if (k == 2'b10) return "R8";
        if (k == 2'b11) return "R9";
        if (byt < 8'd32) return "R6";
        return "R7";
    endfunction

    logic [31:0] vals [6] = '{32'h8000_0001, 32'hA5C3_0F96, 32'h7FFF_FFFE,
                              32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678};

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        use_imm = 1'b0; imm_field = '0; rm_value = '0; shift_kind = '0;
        amt_from_reg = 1'b0; shamt_imm = '0; rs_low_byte = '0; carry_in = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Quiet state: all-zero inputs give a zero operand and zero carry (R1)
        drive(1'b0, 12'h000, 32'h0, 2'b00, 1'b0, 5'd0, 8'd0, 1'b0);
        check("R1", {carry_out, operand_out}, 33'd0);

        // Worked example: base 0x40, rotate field 13 -> 0x1000 (R1)
        drive(1'b1, 12'hD40, 32'h0, 2'b00, 1'b0, 5'd0, 8'd0, 1'b0);
        check("R1", {1'b0, operand_out}, {1'b0, 32'h0000_1000});

        // Exhaustive constant sweep with both carry values (R1, R2)
        for (int f = 0; f < 4096; f++) begin
            for (int c = 0; c < 2; c++) begin
                logic [32:0] e;
                e = ref_imm(12'(f), 1'(c));
                drive(1'b1, 12'(f), 32'hDEAD_BEEF, 2'(f), 1'(f >> 3), 5'(f), 8'(f), 1'(c));
                check("R1", {1'b0, operand_out}, {1'b0, e[31:0]});
                check("R2", {carry_out, 32'd0}, {e[32], 32'd0});
            end
        end

        // Instruction-field amounts: every kind, every amount (R3, R4, R5)
        for (int vi = 0; vi < 6; vi++)
            for (int k = 0; k < 4; k++)
                for (int n = 0; n < 32; n++)
                    for (int c = 0; c < 2; c++) begin
                        drive(1'b0, 12'h5A5, vals[vi], 2'(k), 1'b0, 5'(n), 8'hFF, 1'(c));
                        check(reg_tag(2'(k), 1'b0, 5'(n), 8'd0), {carry_out, operand_out},
                              ref_reg(vals[vi], 2'(k), 1'b0, 5'(n), 8'd0, 1'(c)));
                    end

        // Register amounts: every byte value, every kind (R6, R7, R8, R9)
        for (int vi = 0; vi < 6; vi++)
            for (int k = 0; k < 4; k++)
                for (int b = 0; b < 256; b++)
                    for (int c = 0; c < 2; c++) begin
                        drive(1'b0, 12'hFFF, vals[vi], 2'(k), 1'b1, 5'(b), 8'(b), 1'(c));
                        check(reg_tag(2'(k), 1'b1, 5'd0, 8'(b)), {carry_out, operand_out},
                              ref_reg(vals[vi], 2'(k), 1'b1, 5'd0, 8'(b), 1'(c)));
                    end

        // Unused source has no effect at the outputs (R10)
        for (int i = 0; i < 64; i++) begin
            drive(1'b1, 12'h3C7, vals[i % 6] ^ 32'(i * 32'h0101_0101), 2'(i), 1'(i >> 2),
                  5'(i * 7), 8'(i * 13), 1'(i >> 1));
            check("R10", {carry_out, operand_out}, ref_imm(12'h3C7, 1'(i >> 1)));
        end
        for (int i = 0; i < 64; i++) begin
            drive(1'b0, 12'(i * 67), 32'hA5C3_0F96, 2'b11, 1'b1, 5'd3, 8'd45, 1'b1);
            check("R10", {carry_out, operand_out},
                  ref_reg(32'hA5C3_0F96, 2'b11, 1'b1, 5'd3, 8'd45, 1'b1));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule